// File: doc/BRIEF.md
# Replay Input Event Logger

This block sits beside one processor and records the inputs the processor cannot reproduce by itself. A later replay of the same program feeds those inputs back in. Three kinds of event are captured:

- an asynchronous interrupt, stamped with the processor's running instruction count;
- the data returned by a programmed I/O load, stamped the same way;
- a word written into memory by the DMA engine.

The DMA engine is treated as a thread of its own. Each DMA record therefore carries a private sequence number in place of an instruction count. Synchronous exceptions and programmed I/O stores are left out, because a replay recreates them.

Each source feeds a one-entry holding buffer. A fixed-priority arbiter merges the three buffers onto a single valid/ready record stream. A source whose buffer is occupied sees its ready signal low until the record has gone out.

Every record is `REC_W = 2 + IC_W + DATA_W` bits wide:

| Bits | Field | Contents |
|------|-------|----------|
| [REC_W-1:REC_W-2] | kind | `00` interrupt, `01` I/O load, `10` DMA write |
| [DATA_W +: IC_W] | stamp | instruction count (interrupt, I/O load) or DMA sequence number (DMA write) |
| [DATA_W-1:0] | value | interrupt type code zero-extended, or I/O load data, or DMA data |

Top module: `replay_input_logger`

## Requirements
- R1: An event with `irq_take_i=1`, `irq_async_i=1` and `irq_ready_o=1` yields a record with kind `00`, stamp equal to `icount_i` in the accepting cycle, and value equal to `irq_code_i` zero-extended.
- R2: An interrupt strobe with `irq_async_i=0` (a synchronous exception) produces no record.
- R3: An I/O access with `io_valid_i=1`, `io_is_load_i=1` and `io_ready_o=1` yields a record with kind `01`, stamp equal to `icount_i` in the accepting cycle, and value equal to `io_rdata_i`.
- R4: An I/O access with `io_is_load_i=0` (a store) is accepted with `io_ready_o=1` and produces no record.
- R5: A DMA write with `dma_valid_i=1` and `dma_ready_o=1` yields a record with kind `10`, stamp equal to the DMA sequence number, and value equal to `dma_data_i`. The sequence number is 0 for the first accepted DMA write and rises by one for each further one.
- R6: When several buffered records wait and no record is stalled, the interrupt record goes out first, then the I/O load record, then the DMA record.
- R7: A source's ready output is low while its buffer holds a record that has not gone out. While `log_valid_o=1` and `log_ready_i=0`, the offered record stays unchanged in the next cycle.
- R8: A record is offered on `log_valid_o` in the cycle that follows its accepting clock edge.
- R9: While `rst` is high and after it falls, `log_valid_o=0`, all ready outputs are 1 and the DMA sequence number restarts at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| icount_i | input | IC_W | Processor instruction count |
| irq_take_i | input | 1 | Interrupt or exception taken this cycle |
| irq_async_i | input | 1 | 1 = asynchronous interrupt, 0 = synchronous exception |
| irq_code_i | input | CODE_W | Interrupt type code |
| irq_ready_o | output | 1 | Interrupt buffer can accept |
| io_valid_i | input | 1 | Programmed I/O access this cycle |
| io_is_load_i | input | 1 | 1 = load, 0 = store |
| io_rdata_i | input | DATA_W | Value returned by the load |
| io_ready_o | output | 1 | I/O buffer can accept |
| dma_valid_i | input | 1 | DMA write into memory this cycle |
| dma_data_i | input | DATA_W | DMA write data |
| dma_ready_o | output | 1 | DMA buffer can accept |
| log_valid_o | output | 1 | Record offered |
| log_ready_i | input | 1 | Consumer takes the record |
| log_data_o | output | REC_W | Record: kind, stamp, value |

## Verification
Timing of a record:

- An event counts as accepted at the clock edge where its valid and ready signals are both high.
- The record is then due one cycle later, since only the holding buffer lies between the input and `log_data_o`.
- The bench drives inputs shortly after a rising edge and samples everything at the falling edge, so the values it reads are exactly those present at the next rising edge.

Directed checks look for a dropped event one cycle after its accepting edge, and look for arbitration order on consecutive cycles with the consumer ready. Under random traffic, each accepted event is queued in the bench per source and compared with the record when that record is handed off.

// File: rtl/rlog_pkg.sv
package rlog_pkg;

    // Record kind codes placed in the two top bits of each record.
    typedef enum logic [1:0] {
        KIND_IRQ  = 2'b00,
        KIND_IOLD = 2'b01,
        KIND_DMA  = 2'b10
    } rec_kind_e;

    // Source indices; a lower index means a higher arbitration priority.
    localparam int NSRC    = 3;
    localparam int SRC_IRQ = 0;
    localparam int SRC_IO  = 1;
    localparam int SRC_DMA = 2;

endpackage

// File: rtl/rlog_slot.sv
module rlog_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic         full_o,
    output logic [W-1:0] dout_o
);
    logic         full_q;
    logic [W-1:0] data_q;

    // One-entry holding buffer.
    // The owner pushes only while the buffer is empty.
    // The arbiter pops only while the buffer is full.
    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
        end else if (push_i) begin
            full_q <= 1'b1;
        end else if (pop_i) begin
            full_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (push_i) begin
            data_q <= din_i;
        end
    end

    assign full_o = full_q;
    assign dout_o = data_q;
endmodule

// File: rtl/rlog_arb.sv
module rlog_arb #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_i,
    input  logic         take_i,
    output logic [N-1:0] gnt_o,
    output logic         any_o
);
    logic [N-1:0] pick;
    logic [N-1:0] held_q;
    logic         hold_q;

    // Fixed priority: the lowest set index wins.
    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < N; i++) begin
            pick[i] = req_i[i] & ~seen;
            seen    = seen | req_i[i];
        end
    end

    // A record offered but not taken keeps its grant, so the output stays stable.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            held_q <= '0;
        end else begin
            hold_q <= any_o & ~take_i;
            held_q <= gnt_o;
        end
    end

    assign any_o = |req_i;
    assign gnt_o = hold_q ? held_q : pick;
endmodule

// File: rtl/rlog_seq.sv
module rlog_seq #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q;

    // Sequence count of the DMA pseudo-thread.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/replay_input_logger.sv
module replay_input_logger
    import rlog_pkg::*;
#(
    parameter int IC_W   = 16,
    parameter int DATA_W = 16,
    parameter int CODE_W = 4,
    localparam int REC_W = 2 + IC_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IC_W-1:0]   icount_i,
    input  logic              irq_take_i,
    input  logic              irq_async_i,
    input  logic [CODE_W-1:0] irq_code_i,
    output logic              irq_ready_o,
    input  logic              io_valid_i,
    input  logic              io_is_load_i,
    input  logic [DATA_W-1:0] io_rdata_i,
    output logic              io_ready_o,
    input  logic              dma_valid_i,
    input  logic [DATA_W-1:0] dma_data_i,
    output logic              dma_ready_o,
    output logic              log_valid_o,
    input  logic              log_ready_i,
    output logic [REC_W-1:0]  log_data_o
);
    logic [NSRC-1:0]  push;
    logic [NSRC-1:0]  pop;
    logic [NSRC-1:0]  full;
    logic [NSRC-1:0]  gnt;
    logic [REC_W-1:0] rec_in [NSRC];
    logic [REC_W-1:0] rec_q  [NSRC];
    logic [IC_W-1:0]  dma_seq;

    assign irq_ready_o = ~full[SRC_IRQ];
    assign io_ready_o  = ~full[SRC_IO];
    assign dma_ready_o = ~full[SRC_DMA];

    // Only asynchronous interrupts, I/O loads and DMA writes are captured.
    // Exceptions and I/O stores are dropped here.
    assign push[SRC_IRQ] = irq_take_i & irq_async_i & irq_ready_o;
    assign push[SRC_IO]  = io_valid_i & io_is_load_i & io_ready_o;
    assign push[SRC_DMA] = dma_valid_i & dma_ready_o;

    always_comb begin
        rec_in[SRC_IRQ] = {KIND_IRQ,  icount_i, DATA_W'(irq_code_i)};
        rec_in[SRC_IO]  = {KIND_IOLD, icount_i, io_rdata_i};
        rec_in[SRC_DMA] = {KIND_DMA,  dma_seq,  dma_data_i};
    end

    rlog_seq #(.W(IC_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .inc_i (push[SRC_DMA]),
        .cnt_o (dma_seq)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_slot
        rlog_slot #(.W(REC_W)) u_slot (
            .clk    (clk),
            .rst    (rst),
            .push_i (push[s]),
            .din_i  (rec_in[s]),
            .pop_i  (pop[s]),
            .full_o (full[s]),
            .dout_o (rec_q[s])
        );
    end

    rlog_arb #(.N(NSRC)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .req_i  (full),
        .take_i (log_ready_i),
        .gnt_o  (gnt),
        .any_o  (log_valid_o)
    );

    assign pop = gnt & {NSRC{log_ready_i}};

    always_comb begin
        log_data_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (gnt[i]) begin
                log_data_o = log_data_o | rec_q[i];
            end
        end
    end
endmodule

// File: rtl/rlog_checker.sv
module rlog_checker #(
    parameter int REC_W = 34
) (
    input logic             clk,
    input logic             rst,
    input logic             irq_take_i,
    input logic             irq_async_i,
    input logic             irq_ready_o,
    input logic             io_valid_i,
    input logic             io_is_load_i,
    input logic             io_ready_o,
    input logic             dma_valid_i,
    input logic             dma_ready_o,
    input logic             log_valid_o,
    input logic             log_ready_i,
    input logic [REC_W-1:0] log_data_o
);
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
        log_valid_o && !log_ready_i |=> log_valid_o && $stable(log_data_o)); // R7

    AST_IRQ_NEXT: assert property (@(posedge clk) disable iff (rst)
        irq_take_i && irq_async_i && irq_ready_o |=> log_valid_o); // R8

    AST_FULL_OFFERS: assert property (@(posedge clk) disable iff (rst)
        !irq_ready_o || !io_ready_o || !dma_ready_o |-> log_valid_o); // R7

    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
        log_valid_o |-> log_data_o[REC_W-1 -: 2] != 2'b11); // R1

    AST_QUIET: assert property (@(posedge clk) disable iff (rst)
        !log_valid_o && !(irq_take_i && irq_async_i)
        && !(io_valid_i && io_is_load_i) && !dma_valid_i |=> !log_valid_o); // R2
endmodule

bind replay_input_logger rlog_checker #(.REC_W(REC_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .irq_take_i   (irq_take_i),
    .irq_async_i  (irq_async_i),
    .irq_ready_o  (irq_ready_o),
    .io_valid_i   (io_valid_i),
    .io_is_load_i (io_is_load_i),
    .io_ready_o   (io_ready_o),
    .dma_valid_i  (dma_valid_i),
    .dma_ready_o  (dma_ready_o),
    .log_valid_o  (log_valid_o),
    .log_ready_i  (log_ready_i),
    .log_data_o   (log_data_o)
);

// File: tb/sim_replay_input_logger.sv
module sim_replay_input_logger;
    localparam int IC_W   = 16;
    localparam int DATA_W = 16;
    localparam int CODE_W = 4;
    localparam int REC_W  = 2 + IC_W + DATA_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [IC_W-1:0]   icnt = '0;
    logic              irq_take = 1'b0, irq_async = 1'b0;
    logic [CODE_W-1:0] irq_code = '0;
    logic              irq_ready;
    logic              io_valid = 1'b0, io_is_load = 1'b0;
    logic [DATA_W-1:0] io_rdata = '0;
    logic              io_ready;
    logic              dma_valid = 1'b0;
    logic [DATA_W-1:0] dma_data = '0;
    logic              dma_ready;
    logic              log_valid;
    logic              log_ready = 1'b1;
    logic [REC_W-1:0]  log_data;

    int checks = 0;
    int failures = 0;
    bit mon_en = 1'b0;
    logic [IC_W-1:0] seq_exp = '0;
    logic [REC_W-1:0] q_irq [$];
    logic [REC_W-1:0] q_io  [$];
    logic [REC_W-1:0] q_dma [$];

    always #10 clk = ~clk;
    always @(posedge clk) icnt <= icnt + 1'b1;

    replay_input_logger #(.IC_W(IC_W), .DATA_W(DATA_W), .CODE_W(CODE_W)) u0 (
        .clk(clk), .rst(rst), .icount_i(icnt),
        .irq_take_i(irq_take), .irq_async_i(irq_async), .irq_code_i(irq_code),
        .irq_ready_o(irq_ready),
        .io_valid_i(io_valid), .io_is_load_i(io_is_load), .io_rdata_i(io_rdata),
        .io_ready_o(io_ready),
        .dma_valid_i(dma_valid), .dma_data_i(dma_data), .dma_ready_o(dma_ready),
        .log_valid_o(log_valid), .log_ready_i(log_ready), .log_data_o(log_data)
    );

    function automatic logic [REC_W-1:0] mk_rec(input logic [1:0] kind,
                                                input logic [IC_W-1:0] stamp,
                                                input logic [DATA_W-1:0] val);
        return {kind, stamp, val};
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_inputs();
        irq_take = 1'b0; io_valid = 1'b0; dma_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(); step();
        @(negedge clk);
        chk(log_valid == 1'b0, "R9 valid low in reset", 64'(log_valid), 64'd0);
        chk({irq_ready, io_ready, dma_ready} == 3'b111, "R9 readies high in reset",
            64'({irq_ready, io_ready, dma_ready}), 64'd7);
        step();
        rst = 1'b0;
        seq_exp = '0;
    endtask

    // Random phase scoreboard: sampled at the falling edge, where the values match those of the coming rising edge.
    always @(negedge clk) begin
        if (mon_en && !rst) begin
            if (irq_take && irq_async && irq_ready)
                q_irq.push_back(mk_rec(2'b00, icnt, DATA_W'(irq_code)));
            if (io_valid && io_is_load && io_ready)
                q_io.push_back(mk_rec(2'b01, icnt, io_rdata));
            if (dma_valid && dma_ready) begin
                q_dma.push_back(mk_rec(2'b10, seq_exp, dma_data));
                seq_exp = seq_exp + 1'b1;
            end
            if (log_valid && log_ready) begin
                logic [REC_W-1:0] e;
                case (log_data[REC_W-1 -: 2])
                    2'b00: begin
                        if (q_irq.size() == 0) chk(1'b0, "R2 unexpected irq record", 64'(log_data), 64'd0);
                        else begin e = q_irq.pop_front(); chk(log_data == e, "R1 irq record", 64'(log_data), 64'(e)); end
                    end
                    2'b01: begin
                        if (q_io.size() == 0) chk(1'b0, "R4 unexpected io record", 64'(log_data), 64'd0);
                        else begin e = q_io.pop_front(); chk(log_data == e, "R3 io load record", 64'(log_data), 64'(e)); end
                    end
                    2'b10: begin
                        if (q_dma.size() == 0) chk(1'b0, "R5 unexpected dma record", 64'(log_data), 64'd0);
                        else begin e = q_dma.pop_front(); chk(log_data == e, "R5 dma record", 64'(log_data), 64'(e)); end
                    end
                    default: chk(1'b0, "R1 illegal kind", 64'(log_data), 64'd0);
                endcase
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [IC_W-1:0] ic_exp;
        void'($urandom(32'd4242));
        do_reset();

        // R1 and R8: an interrupt appears one cycle after its accepting edge.
        log_ready = 1'b1;
        irq_take = 1'b1; irq_async = 1'b1; irq_code = 4'hB; ic_exp = icnt;
        step(); idle_inputs();
        @(negedge clk);
        chk(log_valid == 1'b1, "R8 record due next cycle", 64'(log_valid), 64'd1);
        chk(log_data == mk_rec(2'b00, ic_exp, 16'h000B), "R1 irq fields",
            64'(log_data), 64'(mk_rec(2'b00, ic_exp, 16'h000B)));
        step();

        // R2: a synchronous exception leaves no record.
        irq_take = 1'b1; irq_async = 1'b0; irq_code = 4'h3;
        step(); idle_inputs();
        @(negedge clk);
        chk(log_valid == 1'b0, "R2 exception not logged", 64'(log_valid), 64'd0);
        step();

        // R3: an I/O load logs its returned value.
        io_valid = 1'b1; io_is_load = 1'b1; io_rdata = 16'hC0DE; ic_exp = icnt;
        step(); idle_inputs();
        @(negedge clk);
        chk(log_data == mk_rec(2'b01, ic_exp, 16'hC0DE) && log_valid, "R3 io load fields",
            64'(log_data), 64'(mk_rec(2'b01, ic_exp, 16'hC0DE)));
        step();

        // R4: an I/O store is accepted and dropped.
        io_valid = 1'b1; io_is_load = 1'b0; io_rdata = 16'h1234;
        @(negedge clk);
        chk(io_ready == 1'b1, "R4 store accepted", 64'(io_ready), 64'd1);
        step(); idle_inputs();
        @(negedge clk);
        chk(log_valid == 1'b0, "R4 store not logged", 64'(log_valid), 64'd0);
        step();

        // R5: the DMA sequence numbers run 0, then 1.
        dma_valid = 1'b1; dma_data = 16'hAAAA;
        step(); idle_inputs();
        @(negedge clk);
        chk(log_data == mk_rec(2'b10, 16'd0, 16'hAAAA), "R5 first dma seq 0",
            64'(log_data), 64'(mk_rec(2'b10, 16'd0, 16'hAAAA)));
        step();
        dma_valid = 1'b1; dma_data = 16'h5555;
        step(); idle_inputs();
        @(negedge clk);
        chk(log_data == mk_rec(2'b10, 16'd1, 16'h5555), "R5 second dma seq 1",
            64'(log_data), 64'(mk_rec(2'b10, 16'd1, 16'h5555)));
        step();

        // R6 and R7: three events in one cycle while the consumer stalls.
        log_ready = 1'b0;
        irq_take = 1'b1; irq_async = 1'b1; irq_code = 4'h1;
        io_valid = 1'b1; io_is_load = 1'b1; io_rdata = 16'h0101;
        dma_valid = 1'b1; dma_data = 16'h0202;
        step(); idle_inputs();
        @(negedge clk);
        chk(log_data[REC_W-1 -: 2] == 2'b00, "R6 irq first", 64'(log_data[REC_W-1 -: 2]), 64'd0);
        chk({irq_ready, io_ready, dma_ready} == 3'b000, "R7 readies low when full",
            64'({irq_ready, io_ready, dma_ready}), 64'd0);
        step();
        @(negedge clk);
        chk(log_valid && log_data[REC_W-1 -: 2] == 2'b00, "R7 held while stalled",
            64'(log_data[REC_W-1 -: 2]), 64'd0);
        log_ready = 1'b1;
        step();
        @(negedge clk);
        chk(log_data[REC_W-1 -: 2] == 2'b01, "R6 io second", 64'(log_data[REC_W-1 -: 2]), 64'd1);
        step();
        @(negedge clk);
        chk(log_data[REC_W-1 -: 2] == 2'b10, "R6 dma third", 64'(log_data[REC_W-1 -: 2]), 64'd2);
        chk(log_data[DATA_W +: IC_W] == 16'd2, "R5 third dma seq 2",
            64'(log_data[DATA_W +: IC_W]), 64'd2);
        step();
        @(negedge clk);
        chk(log_valid == 1'b0, "R6 all drained", 64'(log_valid), 64'd0);

        // R9: reset restarts the DMA sequence.
        do_reset();
        dma_valid = 1'b1; dma_data = 16'h7777;
        step(); idle_inputs();
        @(negedge clk);
        chk(log_data == mk_rec(2'b10, 16'd0, 16'h7777), "R9 dma seq restarts",
            64'(log_data), 64'(mk_rec(2'b10, 16'd0, 16'h7777)));
        step();

        // Constrained random traffic checked through per-source queues.
        do_reset();
        mon_en = 1'b1;
        for (int n = 0; n < 3000; n++) begin
            irq_take   = ($urandom % 6) == 0;
            irq_async  = ($urandom % 4) != 0;
            irq_code   = CODE_W'($urandom);
            io_valid   = ($urandom % 3) == 0;
            io_is_load = $urandom % 2;
            io_rdata   = DATA_W'($urandom);
            dma_valid  = ($urandom % 3) == 0;
            dma_data   = DATA_W'($urandom);
            log_ready  = ($urandom % 4) != 0;
            step();
        end
        idle_inputs();
        log_ready = 1'b1;
        repeat (8) step();
        @(negedge clk);
        chk(q_irq.size() + q_io.size() + q_dma.size() == 0, "R5 every accepted event logged",
            64'(q_irq.size() + q_io.size() + q_dma.size()), 64'd0);
        mon_en = 1'b0;

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule